// File: doc/BRIEF.md
# Clear-on-Read Alarm Status Register

This block keeps two 8-bit sticky alarm status registers for a hardware monitor. The live out-of-limit flags from the voltage, temperature and fan comparators are latched into a primary and a secondary register. An active-low alert line is asserted whenever an unmasked latched bit is set.

A host reads a status register through a read strobe and an address. The read returns the latched contents, and it clears each bit whose condition has gone away. A bit whose condition is still present stays set, so the next read reports it again. The top bit of the primary register is not stored: it shows the OR of the whole secondary register. Software can therefore poll one register and read the secondary register only when that bit is set. Two mask registers, written through the same address space, select which latched bits drive the alert.

Top module: `alarm_status_top`

## Requirements
- R1: After reset, both status registers and both mask registers are 0x00, `alert_no` is 1, and `rd_data_o` is 0x00.
- R2: A condition input that is high at a rising clock edge sets its status bit at that edge. The bit stays set over later edges with no clearing read of its register, even after the condition has dropped.
- R3: A read strobe at address 0 (primary) or 1 (secondary) clears, at that edge, every bit of the addressed register whose condition is low at that edge. A bit whose condition is high at that edge is set after it, whether it was set before or not.
- R4: `rd_data_o` is registered. It changes at the edge that samples `rd_en_i` and shows the addressed register as it was before that edge's update. A read of one status register leaves the other unchanged.
- R5: Primary bits 6..1 latch `prim_alarm_i[6:1]`. Bit 0 latches `prim_alarm_i[0]` (2.5 V rail) when `therm_mode_i` is 0. It latches `therm_timer_i` when `therm_mode_i` is 1, and in that mode the rail input is ignored.
- R6: Primary read bit 7 equals the OR of all secondary status bits. A primary read never clears it.
- R7: `alert_no` is 0 exactly when a primary bit 6..0 is set with its primary mask bit 0, or a secondary bit is set with its secondary mask bit 0. Primary bit 7 has no alert path, so a secondary mask of 0xFF keeps `alert_no` at 1 while primary bit 7 reads 1.
- R8: A write strobe at address 2 loads primary mask bits 6..0, and bit 7 reads back 0. A write at address 3 loads the secondary mask. Writes at addresses 0 and 1 change nothing. Reads at addresses 2 and 3 return the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_alarm_i | input | 7 | Live primary conditions; bit 0 is the 2.5 V rail |
| therm_mode_i | input | 1 | Selects the thermal timer as the source of primary bit 0 |
| therm_timer_i | input | 1 | Thermal timer limit exceeded |
| sec_alarm_i | input | SEC_W (8) | Live secondary conditions |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 primary, 1 secondary, 2 primary mask, 3 secondary mask |
| wr_data_i | input | 8 | Write data for the mask registers |
| rd_data_o | output | 8 | Registered read data |
| alert_no | output | 1 | Alert, active low |

## Verification
A condition driven before edge k is latched at edge k, so `alert_no` can be checked at the falling edge after k. Read data is sampled at the falling edge after the edge that takes the strobe, and it must hold the pre-clear value. The driver task pushes each expected read value into a queue. The monitor pops that value one cycle after it sees the strobe, which keeps every comparison aligned with the single register stage. The effect of a clear is checked by a second read, and by the alert level at the falling edge after the clearing edge.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int PRIM_W = 7;  // latched primary bits, bit 7 is the summary

  typedef enum logic [ADDR_W-1:0] {
    SEL_PRIM  = 2'd0,
    SEL_SEC   = 2'd1,
    SEL_PMASK = 2'd2,
    SEL_SMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/alarm_src_sel.sv
module alarm_src_sel #(
  parameter int  W      = 7,
  parameter bit  THERM_EN = 1'b1
) (
  input  logic [W-1:0] raw_i,
  input  logic         therm_mode_i,
  input  logic         therm_timer_i,
  output logic [W-1:0] cond_o
);
  generate
    if (THERM_EN) begin : g_therm
      assign cond_o[0] = therm_mode_i ? therm_timer_i : raw_i[0];
    end else begin : g_plain
      logic unused_therm;
      assign unused_therm = therm_mode_i ^ therm_timer_i;
      assign cond_o[0] = raw_i[0];
    end
  endgenerate
  assign cond_o[W-1:1] = raw_i[W-1:1];
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         clr_req_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_q[i] <= 1'b0;
      else if (cond_i[i]) stat_q[i] <= 1'b1;      // new condition wins over clear
      else if (clr_req_i) stat_q[i] <= 1'b0;
    end

    assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond_i[i] |=> stat_q[i]);
    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_req_i) |=> stat_q[i]);
    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_req_i && !cond_i[i]) |=> !stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/alert_gen.sv
module alert_gen #(
  parameter int PW = 7,
  parameter int SW = 8
) (
  input  logic [PW-1:0] prim_stat_i,
  input  logic [PW-1:0] prim_mask_i,
  input  logic [SW-1:0] sec_stat_i,
  input  logic [SW-1:0] sec_mask_i,
  output logic          alert_no
);
  logic prim_hit, sec_hit;
  assign prim_hit = |(prim_stat_i & ~prim_mask_i);
  assign sec_hit  = |(sec_stat_i & ~sec_mask_i);
  assign alert_no = ~(prim_hit | sec_hit);
endmodule

// File: rtl/alarm_status_top.sv
module alarm_status_top
  import alarm_pkg::*;
#(
  parameter int SEC_W    = 8,
  parameter bit THERM_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PRIM_W-1:0]   prim_alarm_i,
  input  logic                therm_mode_i,
  input  logic                therm_timer_i,
  input  logic [SEC_W-1:0]    sec_alarm_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                alert_no
);
  localparam int SEC_PAD = DATA_W - SEC_W;

  reg_sel_e            sel;
  logic [PRIM_W-1:0]   prim_cond, prim_q, prim_mask_q;
  logic [SEC_W-1:0]    sec_q, sec_mask_q;
  logic                rd_prim, rd_sec, summary;
  logic [DATA_W-1:0]   rd_mux, rd_q;

  assign sel     = reg_sel_e'(addr_i);
  assign rd_prim = rd_en_i && (sel == SEL_PRIM);
  assign rd_sec  = rd_en_i && (sel == SEL_SEC);

  alarm_src_sel #(.W(PRIM_W), .THERM_EN(THERM_EN)) u_src (
    .raw_i(prim_alarm_i), .therm_mode_i(therm_mode_i),
    .therm_timer_i(therm_timer_i), .cond_o(prim_cond));

  status_bank #(.W(PRIM_W)) u_prim (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(prim_cond),
    .clr_req_i(rd_prim), .stat_o(prim_q));

  status_bank #(.W(SEC_W)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(sec_alarm_i),
    .clr_req_i(rd_sec), .stat_o(sec_q));

  assign summary = |sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_mask_q <= '0;
      sec_mask_q  <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_PMASK) prim_mask_q <= wr_data_i[PRIM_W-1:0];
      if (sel == SEL_SMASK) sec_mask_q  <= wr_data_i[SEC_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PRIM:  rd_mux = {summary, prim_q};
      SEL_SEC:   rd_mux = {{SEC_PAD{1'b0}}, sec_q};
      SEL_PMASK: rd_mux = {1'b0, prim_mask_q};
      default:   rd_mux = {{SEC_PAD{1'b0}}, sec_mask_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end
  assign rd_data_o = rd_q;

  alert_gen #(.PW(PRIM_W), .SW(SEC_W)) u_alert (
    .prim_stat_i(prim_q), .prim_mask_i(prim_mask_q),
    .sec_stat_i(sec_q), .sec_mask_i(sec_mask_q), .alert_no(alert_no));

  assert_summary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_prim |=> (rd_data_o[DATA_W-1] == $past(|sec_q)));
  assert_sec_alert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sec_q & ~sec_mask_q)) |-> !alert_no);
  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_q == '0 && sec_q == '0) |-> alert_no);
  assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (sel == SEL_PRIM || sel == SEL_SEC)) |=>
      ($stable(prim_mask_q) && $stable(sec_mask_q)));
  assert_rd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/alarm_status_top_test.sv
module alarm_status_top_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [6:0] prim_alarm_i = '0;
  logic       therm_mode_i = 1'b0, therm_timer_i = 1'b0;
  logic [7:0] sec_alarm_i = '0;
  logic       rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       alert_no;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       issued_d = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alarm_status_top uut (.*);

  always @(posedge clk_i) begin
    issued_d <= rd_en_i;
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: compare each read one cycle after its strobe
  always @(negedge clk_i) begin
    if (issued_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data_o !== e) begin
        errors++;
        $display("FAIL %s rd_data actual %h expected %h", t, rd_data_o, e);
      end
    end
  end

  task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string t);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_prim(input int b);
    prim_alarm_i[b] = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    prim_alarm_i[b] = 1'b0;
  endtask

  task automatic pulse_sec(input int b);
    sec_alarm_i[b] = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    sec_alarm_i[b] = 1'b0;
  endtask

  task automatic chk_alert(input logic e, input string t);
    checks++;
    if (alert_no !== e) begin
      errors++;
      $display("FAIL %s alert_no actual %b expected %b", t, alert_no, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_alert(1'b1, "R1 reset alert");
    checks++;
    if (rd_data_o !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset rd_data actual %h expected 00", rd_data_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_read(2'd0, 8'h00, "R1 primary after reset");
    do_read(2'd3, 8'h00, "R1 sec mask after reset");

    // single pulse: latch, alert, clear on read
    pulse_prim(3);
    chk_alert(1'b0, "R7 unmasked primary alert");
    do_read(2'd0, 8'h08, "R2 sticky 5V bit");
    chk_alert(1'b1, "R3 alert released after clear");
    do_read(2'd0, 8'h00, "R3 cleared after read");

    // condition still active at read keeps the bit
    prim_alarm_i[2] = 1'b1;
    @(negedge clk_i);
    do_read(2'd0, 8'h04, "R3 active first read");
    do_read(2'd0, 8'h04, "R3 active bit survives read");
    prim_alarm_i[2] = 1'b0;
    do_read(2'd0, 8'h04, "R3 read after drop");
    do_read(2'd0, 8'h00, "R3 gone after drop and read");

    // bit 0 source selection
    therm_mode_i = 1'b1;
    pulse_prim(0);
    do_read(2'd0, 8'h00, "R5 rail ignored in thermal mode");
    therm_timer_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    therm_timer_i = 1'b0;
    do_read(2'd0, 8'h01, "R5 thermal timer sets bit0");
    therm_mode_i = 1'b0;
    pulse_prim(0);
    do_read(2'd0, 8'h01, "R5 rail sets bit0");
    pulse_prim(6);
    do_read(2'd0, 8'h40, "R5 remote2 on bit6");

    // summary bit
    pulse_sec(5);
    do_read(2'd0, 8'h80, "R6 summary set");
    do_read(2'd0, 8'h80, "R6 summary not cleared by primary read");
    do_read(2'd1, 8'h20, "R4 secondary intact after primary read");
    do_read(2'd1, 8'h00, "R3 secondary cleared");
    do_read(2'd0, 8'h00, "R6 summary follows secondary");

    // masks
    do_write(2'd3, 8'hFF);
    pulse_sec(1);
    chk_alert(1'b1, "R7 secondary fully masked");
    do_read(2'd0, 8'h80, "R7 summary shows while masked");
    do_read(2'd1, 8'h02, "R4 masked secondary latched");
    do_write(2'd2, 8'h7F);
    pulse_prim(6);
    chk_alert(1'b1, "R7 primary masked");
    do_read(2'd0, 8'h40, "R7 masked primary latched");
    do_write(2'd0, 8'h00);
    do_write(2'd1, 8'h00);
    do_read(2'd2, 8'h7F, "R8 primary mask kept");
    do_read(2'd3, 8'hFF, "R8 secondary mask kept");
    do_write(2'd2, 8'hF7);
    do_read(2'd2, 8'h77, "R8 primary mask bit7 reads 0");
    pulse_prim(3);
    chk_alert(1'b0, "R7 unmasked bit3 alerts");
    do_read(2'd0, 8'h08, "R2 bit3 latched");

    // condition arriving together with a read
    prim_alarm_i[1] = 1'b1;
    do_read(2'd0, 8'h00, "R4 pre-clear value on collision");
    prim_alarm_i[1] = 1'b0;
    do_read(2'd0, 8'h02, "R3 new condition wins over clear");
    do_read(2'd0, 8'h00, "R3 collision bit cleared later");

    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule